// File: doc/BRIEF.md
# Stepper Rotor Step Detection Sequencer

This block runs the check that follows every monitored drive pulse of a bipolar watch stepping motor. A single strobe marks the start of the drive pulse and carries the step direction, the drive pulse width code and the detection time-limit code. The block lets the pulse controller keep the bridge while the pulse is being driven. After that it takes over the bridge switches. First it shorts the winding through both high-side switches to dump the stored energy. Next it opens every drive switch. Then it sends out short sense pulses on alternating switch pairs.

During each sense pulse the block samples two comparator flags that are already synchronized. One flag marks an induced current above the positive threshold and the other marks one below the negative threshold. The rotor is judged to have stepped only when a positive detection comes first and a negative detection follows within the programmed limit. The detection window is fixed at 1024 ticks, counted from the start of the drive pulse. When it closes, the block gives the pulse controller a one-tick done strobe together with an ok flag. The controller uses that result to choose the next drive level.

One clock cycle is one tick of the 32.768 kHz base, so 32 ticks are about 0.98 ms.

Top module: `stepdet_seq`

## Requirements
- R1: While reset is asserted and after it is released, with no start, sw_ctl is 0, done is 0 and ok is 0. The dir, pw_code and lim_code inputs are captured on the tick where start is accepted, and later changes to them have no effect on the sequence in progress.
- R2: Call the edge that samples start tick 0, and let P = 32*(pw_code+1). For ticks 0..P-1, sw_ctl is 0 (the bridge belongs to the pulse controller). For ticks P..P+31 it is 6'b000011 (motor shorted through both high-side switches). For ticks P+32..P+63 it is 0 (all switches open). sw_ctl bits are: [0] high-side A, [1] high-side B, [2] low-side A, [3] low-side B, [4] sense A, [5] sense B.
- R3: From tick P+64 up to tick 1023, sampling repeats with a 16-tick period, counted from P+64. Offsets 0-1 drive the first sense pair and offsets 8-9 drive the second. All other offsets short the motor (6'b000011). With dir=0 the first pair is 6'b010010 and the second is 6'b100001. With dir=1 the two pairs swap.
- R4: The comparator flags are read only on the second tick of each sense pulse (sampling offsets 1 and 9). Flag values on any other tick have no effect.
- R5: The result is success when a positive flag is read and a negative flag is then read at a later sample, at most L = 32*(4+lim_code) ticks after it. A negative flag read exactly L ticks later is accepted. One read L+8 ticks later is not.
- R6: A negative flag read before any positive flag is ignored and starts no timing. A negative flag read in the same sample as the first positive flag is ignored.
- R7: Only the first positive flag starts the timer. If no positive flag is read, or the limit runs out before a negative flag is read, the result is failure. A result of failure cannot change to success before the window closes.
- R8: done is high for exactly one tick, the tick at offset 1024 from the start edge. ok is valid in that same tick and is 0 whenever done is 0.
- R9: A start strobe that arrives while a sequence is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock (32.768 kHz base) |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Strobe at start of a monitored drive pulse |
| dir | input | 1 | Step direction of the pulse |
| pw_code | input | 3 | Drive pulse width, (code+1)*32 ticks |
| lim_code | input | 3 | Detection time limit, (4+code)*32 ticks |
| pos_det | input | 1 | Synchronized positive-level comparator flag |
| neg_det | input | 1 | Synchronized negative-level comparator flag |
| sw_ctl | output | 6 | Bridge and sense switch enables |
| done | output | 1 | One-tick end-of-window strobe |
| ok | output | 1 | Step detected, valid with done |

## Verification
The bench tries the decision with several directed flag patterns. These include a negative detection exactly on the limit and one sample past it, negatives that arrive before any positive, a positive and a negative in the same sample, a timeout followed by a later valid-looking pair, no detection at all, and a pair cut off by the window end at the longest pulse width. Each of these separates a correct ordering-and-timeout rule from one that is off by one sample or does not lock its result. Seeded random trials then combine sparse random flag patterns with random pulse width, limit and direction, and put noise on the flags outside the sense pulses. The noise shows whether the sampling instant is right. Changing the inputs while a sequence runs, and sending a second start during one, show whether the configuration is captured and whether a busy start is ignored. The switch pattern is compared on every tick against a model of the phase timing, which separates the drive, short, open and sampling boundaries and the direction swap.

// File: rtl/stepdet_pkg.sv
package stepdet_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_DRIVE  = 3'd1,
    PH_SHORT  = 3'd2,
    PH_OPEN   = 3'd3,
    PH_SAMPLE = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    RES_PEND = 2'd0,
    RES_OKAY = 2'd1,
    RES_FAIL = 2'd2
  } verdict_e;

  localparam int SW_W = 6;
  // bit map: 0 hi_a, 1 hi_b, 2 lo_a, 3 lo_b, 4 sense_a, 5 sense_b
  localparam logic [SW_W-1:0] PAT_OFF   = 6'b000000;
  localparam logic [SW_W-1:0] PAT_SHORT = 6'b000011;
  localparam logic [SW_W-1:0] PAT_SNS_A = 6'b010010;
  localparam logic [SW_W-1:0] PAT_SNS_B = 6'b100001;

endpackage

// File: rtl/stepdet_rst_sync.sv
module stepdet_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/stepdet_timer.sv
module stepdet_timer
  import stepdet_pkg::*;
#(
  parameter int SLOT   = 32,
  parameter int WINDOW = 1024,
  parameter int PERIOD = 16,
  parameter int CODE_W = 3,
  localparam int CNT_W = $clog2(WINDOW + 1),
  localparam int SUB_W = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir_in,
  input  logic [CODE_W-1:0] pw_in,
  input  logic [CODE_W-1:0] lim_in,
  output phase_e            phase,
  output logic [SUB_W-1:0]  sub,
  output logic              dir_q,
  output logic [CODE_W-1:0] lim_q,
  output logic              accept,
  output logic              win_end
);
  phase_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [SUB_W-1:0]  sub_q, sub_d;
  logic [CODE_W-1:0] pw_q;
  logic              load_cfg;
  logic [CNT_W-1:0]  drive_len;

  assign drive_len = (CNT_W'(pw_q) + CNT_W'(1)) * CNT_W'(SLOT);
  assign accept    = (state_q == PH_IDLE) && start;
  assign load_cfg  = accept;
  assign win_end   = (state_q == PH_SAMPLE) && (cnt_q == CNT_W'(WINDOW - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sub_d   = sub_q;
    if (state_q == PH_IDLE) begin
      if (start) begin
        state_d = PH_DRIVE;
        cnt_d   = '0;
        sub_d   = '0;
      end
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      unique case (state_q)
        PH_DRIVE:
          if (cnt_q == drive_len - CNT_W'(1)) state_d = PH_SHORT;
        PH_SHORT:
          if (cnt_q == drive_len + CNT_W'(SLOT - 1)) state_d = PH_OPEN;
        PH_OPEN:
          if (cnt_q == drive_len + CNT_W'(2 * SLOT - 1)) begin
            state_d = PH_SAMPLE;
            sub_d   = '0;
          end
        PH_SAMPLE: begin
          sub_d = (sub_q == SUB_W'(PERIOD - 1)) ? '0 : sub_q + SUB_W'(1);
          if (win_end) state_d = PH_IDLE;
        end
        default: state_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      sub_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sub_q   <= sub_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      pw_q  <= '0;
      lim_q <= '0;
    end else if (load_cfg) begin
      dir_q <= dir_in;
      pw_q  <= pw_in;
      lim_q <= lim_in;
    end
  end

  assign phase = state_q;
  assign sub   = sub_q;

  // R1 R9: configuration frozen while a sequence runs
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PH_IDLE) |=> $stable({dir_q, pw_q, lim_q}));
  // R8: the window end always returns the sequencer to idle
  a_r8_window_closes: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> (state_q == PH_IDLE));
  // R2: the open phase is only left for sampling
  a_r2_open_then_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_OPEN) |=> (state_q == PH_OPEN || state_q == PH_SAMPLE));
endmodule

// File: rtl/stepdet_bridge.sv
module stepdet_bridge
  import stepdet_pkg::*;
#(
  parameter int PERIOD  = 16,
  parameter int PULSE_W = 2,
  localparam int SUB_W  = $clog2(PERIOD),
  localparam int HALF   = PERIOD / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic [SUB_W-1:0] sub,
  input  logic             dir,
  output logic [SW_W-1:0]  sw,
  output logic             strobe
);
  logic first_pair, second_pair;

  assign first_pair  = (sub < SUB_W'(PULSE_W));
  assign second_pair = (sub >= SUB_W'(HALF)) && (sub < SUB_W'(HALF + PULSE_W));

  always_comb begin
    sw     = PAT_OFF;
    strobe = 1'b0;
    unique case (phase)
      PH_SHORT: sw = PAT_SHORT;
      PH_SAMPLE: begin
        if (first_pair)       sw = dir ? PAT_SNS_B : PAT_SNS_A;
        else if (second_pair) sw = dir ? PAT_SNS_A : PAT_SNS_B;
        else                  sw = PAT_SHORT;
        strobe = (sub == SUB_W'(PULSE_W - 1)) || (sub == SUB_W'(HALF + PULSE_W - 1));
      end
      default: sw = PAT_OFF;
    endcase
  end

  // R3: never sense on both legs at once
  a_r3_single_sense: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw[5:4]));
  // R4: flags are read only while a sense pulse is applied
  a_r4_strobe_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (sw[4] || sw[5]));
endmodule

// File: rtl/stepdet_judge.sv
module stepdet_judge
  import stepdet_pkg::*;
#(
  parameter int SLOT     = 32,
  parameter int LIM_BASE = 4,
  parameter int CODE_W   = 3,
  localparam int TMR_W   = $clog2((LIM_BASE + (1 << CODE_W)) * SLOT + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              strobe,
  input  logic              pos,
  input  logic              neg,
  input  logic [CODE_W-1:0] lim,
  output verdict_e          verdict
);
  verdict_e         verdict_q, verdict_d;
  logic             armed_q, armed_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic [TMR_W-1:0] limit;

  assign limit = (TMR_W'(LIM_BASE) + TMR_W'(lim)) * TMR_W'(SLOT);

  always_comb begin
    verdict_d = verdict_q;
    armed_d   = armed_q;
    tmr_d     = tmr_q;
    if (clear) begin
      verdict_d = RES_PEND;
      armed_d   = 1'b0;
      tmr_d     = '0;
    end else if (verdict_q == RES_PEND) begin
      if (armed_q) begin
        if (strobe && neg && (tmr_q <= limit)) verdict_d = RES_OKAY;
        else if (tmr_q > limit)                verdict_d = RES_FAIL;
        else                                   tmr_d     = tmr_q + TMR_W'(1);
      end else if (strobe && pos) begin
        armed_d = 1'b1;
        tmr_d   = TMR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_q <= RES_PEND;
      armed_q   <= 1'b0;
      tmr_q     <= '0;
    end else begin
      verdict_q <= verdict_d;
      armed_q   <= armed_d;
      tmr_q     <= tmr_d;
    end
  end

  assign verdict = verdict_q;

  // R7: a settled verdict holds until the next sequence
  a_r7_verdict_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_q != RES_PEND && !clear) |=> $stable(verdict_q));
  // R6: success cannot come before a positive detection has armed the timer
  a_r6_no_ok_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict_q == RES_PEND && !armed_q && !clear) |=> (verdict_q != RES_OKAY));
  // R5: timer never runs past the limit while still pending
  a_r5_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && verdict_q == RES_PEND) |-> (tmr_q <= limit + TMR_W'(1)));
endmodule

// File: rtl/stepdet_seq.sv
module stepdet_seq
  import stepdet_pkg::*;
#(
  parameter int SLOT     = 32,
  parameter int WINDOW   = 1024,
  parameter int PERIOD   = 16,
  parameter int PULSE_W  = 2,
  parameter int LIM_BASE = 4,
  parameter int CODE_W   = 3,
  localparam int SUB_W   = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              dir,
  input  logic [CODE_W-1:0] pw_code,
  input  logic [CODE_W-1:0] lim_code,
  input  logic              pos_det,
  input  logic              neg_det,
  output logic [SW_W-1:0]   sw_ctl,
  output logic              done,
  output logic              ok
);
  logic              rst_n_s;
  phase_e            phase;
  logic [SUB_W-1:0]  sub;
  logic              dir_q;
  logic [CODE_W-1:0] lim_q;
  logic              accept, win_end, strobe;
  verdict_e          verdict;
  logic              done_q, ok_q;

  stepdet_rst_sync u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_s)
  );

  stepdet_timer #(.SLOT(SLOT), .WINDOW(WINDOW), .PERIOD(PERIOD), .CODE_W(CODE_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .start(start), .dir_in(dir), .pw_in(pw_code),
    .lim_in(lim_code), .phase(phase), .sub(sub), .dir_q(dir_q), .lim_q(lim_q),
    .accept(accept), .win_end(win_end)
  );

  stepdet_bridge #(.PERIOD(PERIOD), .PULSE_W(PULSE_W)) u_bridge (
    .clk(clk), .rst_n(rst_n_s), .phase(phase), .sub(sub), .dir(dir_q),
    .sw(sw_ctl), .strobe(strobe)
  );

  stepdet_judge #(.SLOT(SLOT), .LIM_BASE(LIM_BASE), .CODE_W(CODE_W)) u_judge (
    .clk(clk), .rst_n(rst_n_s), .clear(accept), .strobe(strobe),
    .pos(pos_det), .neg(neg_det), .lim(lim_q), .verdict(verdict)
  );

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      done_q <= win_end;
      ok_q   <= win_end && (verdict == RES_OKAY);
    end
  end

  assign done = done_q;
  assign ok   = ok_q;

  // R8: done lasts one tick
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done);
  // R8: ok only together with done
  a_r8_ok_with_done: assert property (@(posedge clk) disable iff (!rst_n_s)
    ok |-> done);
endmodule

// File: tb/stepdet_seq_tb.sv
module stepdet_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start, dir, pos_det, neg_det;
  logic [2:0] pw_code, lim_code;
  logic [5:0] sw_ctl;
  logic       done, ok;
  int         n_run = 0, n_fail = 0;
  bit         finished = 0;

  always #10 clk = ~clk;

  stepdet_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir(dir), .pw_code(pw_code),
    .lim_code(lim_code), .pos_det(pos_det), .neg_det(neg_det),
    .sw_ctl(sw_ctl), .done(done), .ok(ok)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nslots(input int pw);
    return (1023 - (32 * (pw + 1) + 65)) / 8 + 1;
  endfunction

  // R2 R3 model of the switch pattern at tick j
  function automatic logic [5:0] exp_sw(input int j, input int pw, input logic d);
    int p = 32 * (pw + 1);
    int o;
    if (j < p) return 6'b000000;
    if (j < p + 32) return 6'b000011;
    if (j < p + 64) return 6'b000000;
    if (j > 1023) return 6'b000000;
    o = (j - p - 64) % 16;
    if (o < 2) return d ? 6'b100001 : 6'b010010;
    if (o >= 8 && o < 10) return d ? 6'b010010 : 6'b100001;
    return 6'b000011;
  endfunction

  // R5 R6 R7 decision model over sample slots (8 ticks apart)
  function automatic logic exp_ok(input logic [127:0] pm, input logic [127:0] nm,
                                  input int pw, input int lim);
    int ns = nslots(pw);
    int sp = -1;
    for (int s = 0; s < ns; s++) if (pm[s] && sp < 0) sp = s;
    if (sp < 0) return 1'b0;
    for (int s = sp + 1; s <= sp + 16 + 4 * lim; s++)
      if (s < ns && nm[s]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic run_trial(input string tag, input logic d, input int pw, input int lim,
                           input logic [127:0] pm, input logic [127:0] nm,
                           input bit noise, input int restart_j);
    int p = 32 * (pw + 1);
    int sw_bad = 0, done_bad = 0, first_j = -1;
    logic [5:0] first_act = 0, first_exp = 0;
    logic e_ok = exp_ok(pm, nm, pw, lim);
    @(negedge clk);
    start = 1; dir = d; pw_code = 3'(pw); lim_code = 3'(lim);
    pos_det = 0; neg_det = 0;
    @(posedge clk);
    for (int j = 0; j <= 1026; j++) begin
      @(negedge clk);
      start = (j == restart_j);
      if (j > 0) begin
        dir = 1'($urandom); pw_code = 3'($urandom); lim_code = 3'($urandom);
      end
      if (j >= p + 65 && j <= 1023 && ((j - p - 65) % 8 == 0)) begin
        pos_det = pm[(j - p - 65) / 8];
        neg_det = nm[(j - p - 65) / 8];
      end else if (noise) begin
        pos_det = 1'($urandom); neg_det = 1'($urandom);
      end else begin
        pos_det = 0; neg_det = 0;
      end
      if (sw_ctl !== exp_sw(j, pw, d)) begin
        sw_bad++;
        if (first_j < 0) begin
          first_j = j; first_act = sw_ctl; first_exp = exp_sw(j, pw, d);
        end
      end
      if (done !== (j == 1024)) done_bad++;
      if (j == 1024) chk({"R5 R6 R7 ok ", tag}, int'(ok), int'(e_ok));
      else if (ok !== 1'b0) done_bad++;
    end
    start = 0; pos_det = 0; neg_det = 0;
    if (sw_bad != 0) $display("  tick %0d sw %b vs %b", first_j, first_act, first_exp);
    chk({"R2 R3 switch pattern ", tag}, int'(first_act), int'(first_exp));
    chk({"R8 done single tick ", tag}, done_bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] pm, nm;
    void'($urandom(32'h5EED_0042));
    rst_n = 0; start = 0; dir = 0; pw_code = 0; lim_code = 0;
    pos_det = 0; neg_det = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset sw", int'(sw_ctl), 0);
    chk("R1 reset done/ok", int'({done, ok}), 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", int'({sw_ctl, done, ok}), 0);

    // R5 boundary: negative exactly at the limit (lim=0 -> 16 slots)
    pm = 0; nm = 0; pm[2] = 1; nm[18] = 1;
    run_trial("R5 at limit", 0, 3, 0, pm, nm, 0, -1);
    // R5 one sample past limit
    pm = 0; nm = 0; pm[2] = 1; nm[19] = 1;
    run_trial("R5 past limit", 0, 3, 0, pm, nm, 0, -1);
    // R6 early negatives ignored, then a valid pair
    pm = 0; nm = 0; nm[0] = 1; nm[1] = 1; pm[4] = 1; nm[9] = 1;
    run_trial("R6 early neg", 1, 1, 2, pm, nm, 0, -1);
    // R6 negatives only
    pm = 0; nm = 0; nm[3] = 1; nm[10] = 1;
    run_trial("R6 neg only", 0, 0, 7, pm, nm, 0, -1);
    // R6 same-sample pair then nothing
    pm = 0; nm = 0; pm[5] = 1; nm[5] = 1;
    run_trial("R6 same sample", 0, 2, 1, pm, nm, 0, -1);
    // R7 timeout locks failure despite later pair
    pm = 0; nm = 0; pm[0] = 1; nm[40] = 1; pm[45] = 1; nm[47] = 1;
    run_trial("R7 timeout lock", 1, 0, 1, pm, nm, 0, -1);
    // R7 no detection at all
    pm = 0; nm = 0;
    run_trial("R7 silent", 0, 4, 3, pm, nm, 0, -1);
    // R8 longest pulse, pair cut off by window end
    pm = 0; nm = 0; pm[nslots(7) - 3] = 1; nm[nslots(7) + 1] = 1;
    run_trial("R8 window cut", 1, 7, 7, pm, nm, 0, -1);
    // R4 noise off-strobe, R9 restart ignored, R1 inputs changed mid-run
    pm = 0; nm = 0; pm[1] = 1; nm[20] = 1;
    run_trial("R4 R9 noise restart", 1, 2, 2, pm, nm, 1, 500);

    for (int t = 0; t < 36; t++) begin
      pm = 0; nm = 0;
      for (int s = 0; s < 128; s++) begin
        pm[s] = ($urandom % 14 == 0);
        nm[s] = ($urandom % 9 == 0);
      end
      run_trial("random", 1'($urandom), int'($urandom % 8), int'($urandom % 8),
                pm, nm, 1'($urandom), ((t % 4) == 0) ? int'(300 + $urandom % 600) : -1);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule